// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General-Call Support

This block is the receive-side front end of an I2C slave. It samples the SCL and SDA lines with the system clock and finds Start and Stop conditions on the bus. After each Start it collects one address byte and checks it against a programmable own address and against the fixed general-call byte. When an address is accepted, the block pulls SDA low for the acknowledge bit, offers the byte on a receive port and goes on to accept data bytes until the next Stop or Start.

Received bytes leave through a valid/ready port. `rx_valid_o` rises when a byte is accepted. `rx_data_o` then holds that byte steady until a cycle with `rx_ready_i` high takes it. If the consumer has not taken the byte when the next byte completes, the block sets an overflow flag, does not acknowledge the new byte and keeps the old one. So a slow consumer turns into a NACK on the bus and no data is lost inside the block.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode, a first-byte match raises an address-update flag, and firmware then puts the low address half on `own_addr_i`. A general call in 10-bit mode skips the second address byte completely.

Top module: `i2c_gc_addr_rx`

## Requirements
- R1: After reset, `sda_pull_o`, `rx_valid_o`, `irq_o`, `ovf_o` and `upd_addr_o` are all low.
- R2: A Start is SDA falling while SCL is high. The 8 bits that follow are taken MSB first on rising SCL edges. A byte b is an own-address match when b[7:1] equals own_addr_i[7:1], b[0] (R/W) is 0 and b[7:1] is not zero. On a match, `sda_pull_o` is high through the ninth SCL clock.
- R3: The byte 0x00 is acknowledged as a general call only while `gc_en_i` is 1. While `gc_en_i` is 0 it gets no acknowledge and is not delivered.
- R4: An accepted byte appears on `rx_data_o` with `rx_valid_o` high from the eighth rising SCL edge. Both stay unchanged until a clock cycle with `rx_ready_i` high, which clears `rx_valid_o`. After a match the delivered byte tells firmware what kind of address it was: 0x00 means general call.
- R5: `irq_o` is set on the falling SCL edge of the ninth clock of an acknowledged byte. Only a one-cycle pulse on `irq_clr_i` clears it.
- R6: If a byte completes while `rx_valid_o` is still high, that byte is not acknowledged, `ovf_o` is set and `rx_data_o` keeps its old value. `irq_clr_i` clears `ovf_o`.
- R7: With `ten_bit_i` = 1, a first-byte own match sets `upd_addr_o`. The flag clears when `own_addr_i` changes value. The second address byte is acknowledged only if it equals all 8 bits of `own_addr_i`, and data bytes follow it.
- R8: With `ten_bit_i` = 1, a general-call match does not set `upd_addr_o`, and the very next byte is taken as data.
- R9: A Stop (SDA rising while SCL is high) returns the block to idle, and bytes clocked while idle are not acknowledged. A Start in the middle of a byte starts a new address phase.
- R10: After a non-matching address byte, every byte up to the next Start gets no acknowledge and nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | When 1, the pad drives SDA low; when 0, SDA is released |
| own_addr_i | input | 8 | Own-address compare byte (upper half of the 10-bit address first, then the low half) |
| ten_bit_i | input | 1 | Selects 10-bit addressing |
| gc_en_i | input | 1 | Enables general-call recognition |
| rx_valid_o | output | 1 | A received byte is waiting (buffer full) |
| rx_data_o | output | 8 | The received byte |
| rx_ready_i | input | 1 | Consumer takes the byte in this cycle |
| irq_o | output | 1 | Interrupt flag, set after an acknowledged byte |
| irq_clr_i | input | 1 | Clears `irq_o` and `ovf_o` |
| ovf_o | output | 1 | A byte arrived while the buffer was full |
| upd_addr_o | output | 1 | Firmware must load the low 10-bit address half |

## Verification
The hardest state to reach from the ports is the second address phase of a 10-bit transfer. It only exists after a first-byte match, and the bench must then change `own_addr_i` in the middle of the transaction while SCL is low. Only then can the second byte decide between acknowledge and skip. The bench gets there by driving the whole bus sequence and changing the address between bytes. It then sends a general call in the same mode, and a data byte that differs from the own address shows whether the second address phase was really skipped. A consumer that holds back `rx_ready_i` produces the overflow path, and an exhaustive sweep of all 256 address bytes, with general call both on and off, covers the compare logic.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_ADDR2 = 3'd2,
    ST_DATA  = 3'd3,
    ST_SKIP  = 3'd4
  } rx_state_e;

  localparam logic [7:0] GEN_CALL_BYTE = 8'h00;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_bit_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic          scl_q, sda_q;

  // synchronizer chains, idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_q  <= scl_sh[LAST];
      sda_q  <= sda_sh[LAST];
    end
  end

  assign scl_rise_o = scl_sh[LAST] & ~scl_q;
  assign scl_fall_o = ~scl_sh[LAST] & scl_q;
  assign start_o    = scl_sh[LAST] & scl_q & sda_q & ~sda_sh[LAST];
  assign stop_o     = scl_sh[LAST] & scl_q & ~sda_q & sda_sh[LAST];
  assign sda_bit_o  = sda_sh[LAST];

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_gc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] own_i,
  input  logic              gc_en_i,
  output logic              gc_hit_o,
  output logic              own_hit_o,
  output logic              full_hit_o
);

  logic upper_eq, upper_zero;

  assign upper_eq   = (byte_i[BYTE_W-1:1] == own_i[BYTE_W-1:1]);
  assign upper_zero = (byte_i[BYTE_W-1:1] == '0);

  assign gc_hit_o   = gc_en_i && (byte_i == GEN_CALL_BYTE[BYTE_W-1:0]);
  assign own_hit_o  = upper_eq && !byte_i[0] && !upper_zero;
  assign full_hit_o = (byte_i == own_i);

endmodule

// File: rtl/i2c_gc_addr_rx.sv
module i2c_gc_addr_rx
  import i2c_gc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [BYTE_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              rx_ready_i,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic              ovf_o,
  output logic              upd_addr_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .sda_bit_o (sda_bit)
  );

  rx_state_e         st_q, nxt_q, dec_nxt;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q, byte_next, buf_q, own_q;
  logic              sda_oe_q, ack_pend_q, ack_phase_q;
  logic              bf_q, irq_q, ovf_q, ua_q;
  logic              gc_hit, own_hit, full_hit;
  logic              bf_eff, dec_hit, dec_ack, dec_ovf, dec_ua;

  assign byte_next = {shreg_q[BYTE_W-2:0], sda_bit};
  assign bf_eff    = bf_q && !rx_ready_i;

  i2c_addr_match #(.BYTE_W(BYTE_W)) u_match (
    .byte_i    (byte_next),
    .own_i     (own_addr_i),
    .gc_en_i   (gc_en_i),
    .gc_hit_o  (gc_hit),
    .own_hit_o (own_hit),
    .full_hit_o(full_hit)
  );

  // byte verdict, evaluated on the last data bit's rising edge
  always_comb begin
    dec_hit = 1'b0;
    dec_ua  = 1'b0;
    dec_nxt = ST_SKIP;
    unique case (st_q)
      ST_ADDR: begin
        if (gc_hit) begin
          dec_hit = 1'b1;
          dec_nxt = ST_DATA;
        end else if (own_hit) begin
          dec_hit = 1'b1;
          dec_ua  = ten_bit_i;
          dec_nxt = ten_bit_i ? ST_ADDR2 : ST_DATA;
        end
      end
      ST_ADDR2: begin
        if (full_hit) begin
          dec_hit = 1'b1;
          dec_nxt = ST_DATA;
        end
      end
      ST_DATA: begin
        dec_hit = 1'b1;
        dec_nxt = ST_DATA;
      end
      default: dec_nxt = ST_SKIP;
    endcase
    dec_ovf = dec_hit && bf_eff;
    dec_ack = dec_hit && !bf_eff;
    if (!dec_ack) dec_ua = 1'b0;
    if (dec_ovf && st_q != ST_DATA) dec_nxt = ST_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      buf_q       <= '0;
      own_q       <= '0;
      sda_oe_q    <= 1'b0;
      ack_pend_q  <= 1'b0;
      ack_phase_q <= 1'b0;
      bf_q        <= 1'b0;
      irq_q       <= 1'b0;
      ovf_q       <= 1'b0;
      ua_q        <= 1'b0;
    end else begin
      own_q <= own_addr_i;
      if (own_q != own_addr_i) ua_q <= 1'b0;
      if (bf_q && rx_ready_i) bf_q <= 1'b0;
      if (irq_clr_i) begin
        irq_q <= 1'b0;
        ovf_q <= 1'b0;
      end

      if (stop_det) begin
        st_q        <= ST_IDLE;
        bitcnt_q    <= '0;
        sda_oe_q    <= 1'b0;
        ack_phase_q <= 1'b0;
      end else if (start_det) begin
        st_q        <= ST_ADDR;
        bitcnt_q    <= '0;
        sda_oe_q    <= 1'b0;
        ack_phase_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise && bitcnt_q < FULL_CNT) begin
          shreg_q  <= byte_next;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            ack_pend_q <= dec_ack;
            nxt_q      <= dec_nxt;
            if (dec_ack) begin
              buf_q <= byte_next;
              bf_q  <= 1'b1;
            end
            if (dec_ovf) ovf_q <= 1'b1;
            if (dec_ua) ua_q <= 1'b1;
          end
        end else if (scl_fall && bitcnt_q == FULL_CNT && !ack_phase_q) begin
          sda_oe_q    <= ack_pend_q;
          ack_phase_q <= 1'b1;
        end else if (scl_fall && ack_phase_q) begin
          if (sda_oe_q) irq_q <= 1'b1;
          sda_oe_q    <= 1'b0;
          ack_phase_q <= 1'b0;
          bitcnt_q    <= '0;
          st_q        <= nxt_q;
        end
      end
    end
  end

  assign sda_pull_o = sda_oe_q;
  assign rx_valid_o = bf_q;
  assign rx_data_o  = buf_q;
  assign irq_o      = irq_q;
  assign ovf_o      = ovf_q;
  assign upd_addr_o = ua_q;

  assert_irq_on_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(sda_oe_q) && $past(scl_fall)));

  assert_hold_until_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_q && !rx_ready_i) |=> (bf_q && $stable(buf_q)));

  assert_no_overwrite_on_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $stable(buf_q));

  assert_upd_only_ten_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ua_q) |-> ten_bit_i);

  assert_release_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe_q);

endmodule

// File: tb/i2c_gc_addr_rx_tb.sv
module i2c_gc_addr_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       sda_pull;
  logic [7:0] own_addr = 8'h5A;
  logic       ten_bit = 1'b0, gc_en = 1'b0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       irq, irq_clr = 1'b0, ovf, upd_addr;
  logic       bus_sda;
  int         n_cmp = 0, n_bad = 0;
  bit         ack;

  always #4 clk = ~clk;

  assign bus_sda = m_sda & ~sda_pull;

  i2c_gc_addr_rx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (bus_sda),
    .sda_pull_o(sda_pull),
    .own_addr_i(own_addr),
    .ten_bit_i (ten_bit),
    .gc_en_i   (gc_en),
    .rx_valid_o(rx_valid),
    .rx_data_o (rx_data),
    .rx_ready_i(rx_ready),
    .irq_o     (irq),
    .irq_clr_i (irq_clr),
    .ovf_o     (ovf),
    .upd_addr_o(upd_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(3);
    m_scl = 1'b1; wclk(6);
    m_sda = 1'b0; wclk(6);
    m_scl = 1'b0; wclk(3);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; wclk(3);
    m_sda = 1'b0; wclk(3);
    m_scl = 1'b1; wclk(6);
    m_sda = 1'b1; wclk(6);
  endtask

  task automatic clock_bit(input logic b);
    m_sda = b; wclk(3);
    m_scl = 1'b1; wclk(6);
    m_scl = 1'b0; wclk(3);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    m_scl = 1'b0; wclk(3);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    m_sda = 1'b1; wclk(3);
    m_scl = 1'b1; wclk(3);
    acked = !bus_sda;
    wclk(3);
    m_scl = 1'b0; wclk(6);
  endtask

  task automatic take_byte();
    rx_ready = 1'b1; wclk(1); rx_ready = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; wclk(1); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wclk(5);
    // R1 reset state
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 upd_addr", upd_addr, 0);
    rst_n = 1'b1;
    wclk(5);

    // R2 R3 R4 R5: every address byte, general call off and on
    for (int g = 0; g < 2; g++) begin
      gc_en = g[0];
      for (int b = 0; b < 256; b++) begin
        logic [7:0] bb;
        bit exp_ack;
        bb = b[7:0];
        exp_ack = (bb == 8'h00 && g == 1) || (bb[7:1] == 7'h2D && !bb[0]);
        bus_start();
        send_byte(bb, ack);
        wclk(4);
        chk(bb == 0 ? "R3 gc ack" : "R2 addr ack", ack, exp_ack);
        chk("R4 rx_valid", rx_valid, exp_ack);
        chk("R5 irq", irq, exp_ack);
        if (exp_ack) chk("R4 rx_data", rx_data, bb);
        bus_stop();
        take_byte();
        clear_irq();
      end
    end
    gc_en = 1'b0;

    // R4 data byte after own address; R5 irq held until clear
    bus_start();
    send_byte(8'h5A, ack);
    take_byte();
    wclk(10);
    chk("R5 irq held", irq, 1);
    clear_irq();
    chk("R5 irq cleared", irq, 0);
    send_byte(8'hC3, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 data", rx_data, 8'hC3);
    bus_stop();
    take_byte(); clear_irq();

    // R6 overflow
    bus_start();
    send_byte(8'h5A, ack);
    clear_irq();
    send_byte(8'h3C, ack);
    chk("R6 nack", ack, 0);
    chk("R6 ovf", ovf, 1);
    chk("R6 data kept", rx_data, 8'h5A);
    chk("R6 irq not set", irq, 0);
    bus_stop();
    clear_irq();
    chk("R6 ovf cleared", ovf, 0);
    take_byte();

    // R10 skip after mismatch
    bus_start();
    send_byte(8'h44, ack);
    send_byte(8'h5A, ack);
    chk("R10 skip nack", ack, 0);
    chk("R10 nothing delivered", rx_valid, 0);
    bus_stop();

    // R9 bytes while idle, then repeated start mid byte
    send_byte(8'h5A, ack);
    chk("R9 idle nack", ack, 0);
    m_scl = 1'b0; wclk(3);
    m_sda = 1'b1; wclk(3);
    m_scl = 1'b1; wclk(6);
    m_sda = 1'b1; wclk(6);
    bus_start();
    for (int i = 7; i >= 5; i--) clock_bit(8'h5A >> i);
    bus_start();
    send_byte(8'h5A, ack);
    chk("R9 restart ack", ack, 1);
    chk("R9 restart data", rx_data, 8'h5A);
    bus_stop();
    take_byte(); clear_irq();

    // R7 10-bit full match
    ten_bit = 1'b1; own_addr = 8'hF6; wclk(2);
    bus_start();
    send_byte(8'hF6, ack);
    chk("R7 first ack", ack, 1);
    chk("R7 upd set", upd_addr, 1);
    take_byte(); clear_irq();
    own_addr = 8'h34; wclk(2);
    chk("R7 upd cleared", upd_addr, 0);
    send_byte(8'h34, ack);
    chk("R7 second ack", ack, 1);
    take_byte(); clear_irq();
    send_byte(8'hA5, ack);
    chk("R7 data ack", ack, 1);
    chk("R7 data", rx_data, 8'hA5);
    bus_stop();
    take_byte(); clear_irq();

    // R7 second byte mismatch
    own_addr = 8'hF6; wclk(2);
    bus_start();
    send_byte(8'hF6, ack);
    take_byte(); clear_irq();
    own_addr = 8'h34; wclk(2);
    send_byte(8'h35, ack);
    chk("R7 second miss nack", ack, 0);
    chk("R7 second miss valid", rx_valid, 0);
    bus_stop();

    // R8 general call in 10-bit mode
    own_addr = 8'hF6; gc_en = 1'b1; wclk(2);
    bus_start();
    send_byte(8'h00, ack);
    chk("R8 gc ack", ack, 1);
    chk("R8 no upd", upd_addr, 0);
    chk("R8 gc byte", rx_data, 8'h00);
    take_byte(); clear_irq();
    send_byte(8'h77, ack);
    chk("R8 data ack", ack, 1);
    chk("R8 data", rx_data, 8'h77);
    bus_stop();
    take_byte(); clear_irq();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule